// File: doc/BRIEF.md
# Wait/Request Handshake Pin Controller

This block drives one shared handshake pin for a serial channel. The pin works in one of two ways. It can stall the CPU with wait states when the CPU touches the data port before the channel can accept or supply a byte. It can also signal a DMA engine that the channel is ready to move a byte. Three configuration bits choose the behaviour: an enable, a function select (wait or request) and a direction select (transmit side or receive side). The block reads the channel's transmit-buffer-empty and receive-character-available flags and the CPU data-access strobe with its read/write qualifier.

The pin is modelled as a drive value plus an output enable, so that the bench and the pad logic can tell "driven high" apart from "floating". In request mode the pin is always driven, and it is pulled low while the selected side is ready. In wait mode the pin floats unless it is holding off a premature access. A second request output, which serves the transmit side only, lets the transmit side raise requests while the main pin serves receive DMA, so both directions can run under DMA at once.

After a request is consumed by an access, it stays inactive for a parameterised number of recovery cycles. This gives the external buffer flags time to settle.

Top module: `xfer_handshake_pin`

## Requirements
- R1: With the function select at 0 (wait) and the enable at 0, `pinOe` is 0 whatever the flags and accesses are.
- R2: With the function select at 1 (request) and the enable at 0, `pinOe` is 1, `pinDrive` is 1 and `txReqN` is 1.
- R3: Enabled request mode with the direction bit at 0 drives `pinDrive` low exactly while `txBufEmpty` is 1, and `rxCharAvail` has no effect. This holds when no access is being made and none is in its recovery window.
- R4: Enabled request mode with the direction bit at 1 drives `pinDrive` low exactly while `rxCharAvail` is 1, and `txBufEmpty` has no effect. The same conditions on accesses apply as in R3.
- R5: In enabled request mode, a matching access returns `pinDrive` to 1 in the same cycle. A matching access is a write (`accWrite`=1) when the direction is 0, and a read (`accWrite`=0) when the direction is 1. A non-matching access leaves the pin unchanged.
- R6: After a matching access, the request stays at 1 for HOLD_CYCLES further cycles (default 1). It then follows the ready flag again.
- R7: Enabled wait mode drives `pinOe`=1 and `pinDrive`=0 while a matching access strobe is present and the selected side is not ready. A non-matching access leaves the pin floating (`pinOe`=0).
- R8: In wait mode, the pin returns to floating in the same cycle that the selected side becomes ready, or that the strobe ends.
- R9: `txReqN` is low only when the block is enabled in request mode with the direction at 1 and `txBufEmpty` is 1, outside a write access and its recovery window. In all other cases it is high.
- R10: Reset clears the recovery windows, so a request is asserted in the first cycle after reset if the side is ready, even if an access was strobed during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgEnable | input | 1 | Enables the wait/request function |
| cfgFuncReq | input | 1 | 0 = wait function, 1 = request function |
| cfgDirRx | input | 1 | 0 = pin serves the transmit side, 1 = receive side |
| txBufEmpty | input | 1 | Transmit buffer can accept a byte |
| rxCharAvail | input | 1 | At least one received byte is available |
| accStrobe | input | 1 | CPU/DMA data-port access in this cycle |
| accWrite | input | 1 | 1 = access is a write, 0 = read |
| pinDrive | output | 1 | Value driven on the handshake pin |
| pinOe | output | 1 | 1 = pin driven, 0 = pin floating |
| txReqN | output | 1 | Transmit-only request, active low, always driven |

## Verification
The pin and the transmit request are combinational in the configuration, flags and strobe. Every R1–R5 and R7–R9 result is therefore due in the same cycle as its stimulus. The bench drives inputs on the falling edge and samples 1 ns later, before the next rising edge. The recovery window of R6 starts at the rising edge that captures an access. The bench checks the pin at one falling edge after the access and at one rising edge later, when the pin should follow the flag again. For R10, the bench strobes during reset and samples in the first cycle after release.

// File: rtl/xfer_hs_pkg.sv
package xfer_hs_pkg;

  // Strobes from control to the pin datapath
  typedef struct packed {
    logic pinLow;   // pull the shared pin low
    logic pinEn;    // drive the shared pin (else float)
    logic txLow;    // pull the transmit-only request low
  } hsStrobe_t;

endpackage

// File: rtl/xfer_hs_holdoff.sv
// Recovery window after a consuming access: busy for HOLD cycles after take.
module xfer_hs_holdoff #(
  parameter int HOLD = 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic take,
  output logic busy
);

  generate
    if (HOLD == 0) begin : g_none
      assign busy = 1'b0;
    end else begin : g_cnt
      localparam int CW = $clog2(HOLD + 1);
      localparam logic [CW-1:0] LOAD = CW'(HOLD);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          cnt <= '0;
        end else if (take) begin
          cnt <= LOAD;
        end else if (cnt != '0) begin
          cnt <= cnt - 1'b1;
        end
      end

      assign busy = (cnt != '0);
    end
  endgenerate

endmodule

// File: rtl/xfer_hs_ctrl.sv
module xfer_hs_ctrl
  import xfer_hs_pkg::*;
#(
  parameter int HOLD_CYCLES = 1
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      cfgEnable,
  input  logic      cfgFuncReq,
  input  logic      cfgDirRx,
  input  logic      txBufEmpty,
  input  logic      rxCharAvail,
  input  logic      accStrobe,
  input  logic      accWrite,
  output hsStrobe_t strobes
);

  logic sideReady;
  logic mainAccess;
  logic txAccess;
  logic mainBusy;
  logic txBusy;
  logic reqLow;
  logic waitLow;

  // Readiness of the side the main pin serves
  assign sideReady  = cfgDirRx ? rxCharAvail : txBufEmpty;
  // Matching access: write for transmit side, read for receive side
  assign mainAccess = accStrobe & (accWrite ^ cfgDirRx);
  assign txAccess   = accStrobe & accWrite;

  xfer_hs_holdoff #(.HOLD(HOLD_CYCLES)) u_mainHold (
    .clk  (clk),
    .rstN (rstN),
    .take (mainAccess),
    .busy (mainBusy)
  );

  xfer_hs_holdoff #(.HOLD(HOLD_CYCLES)) u_txHold (
    .clk  (clk),
    .rstN (rstN),
    .take (txAccess),
    .busy (txBusy)
  );

  always_comb begin
    reqLow  = cfgEnable & cfgFuncReq & sideReady & ~mainAccess & ~mainBusy;
    waitLow = cfgEnable & ~cfgFuncReq & mainAccess & ~sideReady;
    strobes.pinLow = reqLow | waitLow;
    strobes.pinEn  = cfgFuncReq | waitLow;
    strobes.txLow  = cfgEnable & cfgFuncReq & cfgDirRx & txBufEmpty
                     & ~txAccess & ~txBusy;
  end

endmodule

// File: rtl/xfer_hs_dpath.sv
module xfer_hs_dpath
  import xfer_hs_pkg::*;
(
  input  hsStrobe_t strobes,
  output logic      pinDrive,
  output logic      pinOe,
  output logic      txReqN
);

  // Idle level is high; a floating pin also presents 1 on the drive value.
  assign pinDrive = ~strobes.pinLow;
  assign pinOe    = strobes.pinEn;
  assign txReqN   = ~strobes.txLow;

endmodule

// File: rtl/xfer_handshake_pin.sv
module xfer_handshake_pin
  import xfer_hs_pkg::*;
#(
  parameter int HOLD_CYCLES = 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic cfgEnable,
  input  logic cfgFuncReq,
  input  logic cfgDirRx,
  input  logic txBufEmpty,
  input  logic rxCharAvail,
  input  logic accStrobe,
  input  logic accWrite,
  output logic pinDrive,
  output logic pinOe,
  output logic txReqN
);

  hsStrobe_t strobes;

  xfer_hs_ctrl #(.HOLD_CYCLES(HOLD_CYCLES)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cfgEnable   (cfgEnable),
    .cfgFuncReq  (cfgFuncReq),
    .cfgDirRx    (cfgDirRx),
    .txBufEmpty  (txBufEmpty),
    .rxCharAvail (rxCharAvail),
    .accStrobe   (accStrobe),
    .accWrite    (accWrite),
    .strobes     (strobes)
  );

  xfer_hs_dpath u_dpath (
    .strobes  (strobes),
    .pinDrive (pinDrive),
    .pinOe    (pinOe),
    .txReqN   (txReqN)
  );

endmodule

// File: rtl/xfer_hs_chk.sv
module xfer_hs_chk (
  input logic clk,
  input logic rstN,
  input logic cfgEnable,
  input logic cfgFuncReq,
  input logic cfgDirRx,
  input logic txBufEmpty,
  input logic rxCharAvail,
  input logic accStrobe,
  input logic accWrite,
  input logic pinDrive,
  input logic pinOe,
  input logic txReqN
);

  // R1
  wait_off_float_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgEnable && !cfgFuncReq) |-> !pinOe);

  // R2
  req_off_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgEnable && cfgFuncReq) |-> (pinOe && pinDrive && txReqN));

  // R5
  req_access_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEnable && cfgFuncReq && accStrobe && (accWrite != cfgDirRx)) |-> pinDrive);

  // R6
  req_holdoff_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEnable && cfgFuncReq && accStrobe && (accWrite != cfgDirRx))
      |=> (pinDrive || !cfgFuncReq));

  // R7
  wait_mismatch_float_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEnable && !cfgFuncReq && accStrobe && (accWrite == cfgDirRx)) |-> !pinOe);

  // R8
  wait_ready_float_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgFuncReq && ((cfgDirRx && rxCharAvail) || (!cfgDirRx && txBufEmpty))) |-> !pinOe);

  // R9
  txreq_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgEnable && cfgFuncReq && cfgDirRx && txBufEmpty) |-> txReqN);

endmodule

bind xfer_handshake_pin xfer_hs_chk u_chk (.*);

// File: tb/xfer_handshake_pin_tb.sv
module xfer_handshake_pin_tb;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgEnable = 1'b0, cfgFuncReq = 1'b0, cfgDirRx = 1'b0;
  logic txBufEmpty = 1'b0, rxCharAvail = 1'b0;
  logic accStrobe = 1'b0, accWrite = 1'b0;
  logic pinDrive, pinOe, txReqN;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xfer_handshake_pin u_dut (
    .clk(clk), .rstN(rstN),
    .cfgEnable(cfgEnable), .cfgFuncReq(cfgFuncReq), .cfgDirRx(cfgDirRx),
    .txBufEmpty(txBufEmpty), .rxCharAvail(rxCharAvail),
    .accStrobe(accStrobe), .accWrite(accWrite),
    .pinDrive(pinDrive), .pinOe(pinOe), .txReqN(txReqN)
  );

  task automatic check(input string tag, input string what,
                       input logic act, input logic exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  // Apply inputs on the falling edge, then settle before sampling
  task automatic drive(input logic en, input logic fr, input logic dr,
                       input logic te, input logic ra,
                       input logic st, input logic wr);
    @(negedge clk);
    cfgEnable = en; cfgFuncReq = fr; cfgDirRx = dr;
    txBufEmpty = te; rxCharAvail = ra; accStrobe = st; accWrite = wr;
    #1;
  endtask

  task automatic t_reset();
    // strobe during reset must not leave a recovery window (R10)
    drive(1, 1, 0, 1, 0, 1, 1);
    rstN = 1'b0;
    repeat (2) @(posedge clk);
    drive(1, 1, 0, 1, 0, 0, 0);
    rstN = 1'b1;
    #1;
    check("R10", "request right after reset", pinDrive, 1'b0);
    drive(0, 0, 0, 0, 0, 0, 0);
    check("R1", "reset idle float", pinOe, 1'b0);
  endtask

  task automatic t_disabled();
    drive(0, 0, 0, 0, 0, 1, 1);
    check("R1", "wait disabled float", pinOe, 1'b0);
    drive(0, 1, 1, 1, 1, 0, 0);
    check("R2", "req disabled oe", pinOe, 1'b1);
    check("R2", "req disabled drive", pinDrive, 1'b1);
    check("R2", "req disabled txReqN", txReqN, 1'b1);
  endtask

  task automatic t_req_tx();
    drive(1, 1, 0, 1, 0, 0, 0);
    check("R3", "tx ready low", pinDrive, 1'b0);
    check("R3", "tx ready oe", pinOe, 1'b1);
    drive(1, 1, 0, 0, 1, 0, 0);
    check("R3", "tx busy, rx ignored", pinDrive, 1'b1);
  endtask

  task automatic t_req_rx();
    drive(1, 1, 1, 0, 1, 0, 0);
    check("R4", "rx avail low", pinDrive, 1'b0);
    drive(1, 1, 1, 1, 0, 0, 0);
    check("R4", "rx empty, tx ignored", pinDrive, 1'b1);
  endtask

  task automatic t_req_consume();
    drive(1, 1, 0, 1, 0, 1, 0);
    check("R5", "non-matching read keeps request", pinDrive, 1'b0);
    drive(1, 1, 0, 1, 0, 1, 1);
    check("R5", "matching write releases same cycle", pinDrive, 1'b1);
    drive(1, 1, 0, 1, 0, 0, 0);
    check("R6", "held high in recovery cycle", pinDrive, 1'b1);
    drive(1, 1, 0, 1, 0, 0, 0);
    check("R6", "request resumes after recovery", pinDrive, 1'b0);
  endtask

  task automatic t_wait();
    drive(1, 0, 0, 0, 0, 1, 1);
    check("R7", "wait oe on premature write", pinOe, 1'b1);
    check("R7", "wait drive low", pinDrive, 1'b0);
    drive(1, 0, 0, 0, 0, 1, 0);
    check("R7", "non-matching read floats", pinOe, 1'b0);
    drive(1, 0, 0, 0, 0, 1, 1);
    drive(1, 0, 0, 1, 0, 1, 1);
    check("R8", "release when ready rises", pinOe, 1'b0);
    drive(1, 0, 1, 0, 0, 1, 0);
    check("R7", "rx wait on premature read", pinOe, 1'b1);
    drive(1, 0, 1, 0, 0, 0, 0);
    check("R8", "release when strobe ends", pinOe, 1'b0);
  endtask

  task automatic t_txreq();
    drive(1, 1, 1, 1, 0, 0, 0);
    check("R9", "tx request active", txReqN, 1'b0);
    check("R9", "main pin idle on rx side", pinDrive, 1'b1);
    drive(1, 1, 1, 1, 0, 1, 1);
    check("R9", "write releases tx request", txReqN, 1'b1);
    drive(1, 1, 1, 1, 0, 0, 0);
    check("R9", "tx request recovery", txReqN, 1'b1);
    drive(1, 1, 1, 1, 0, 0, 0);
    check("R9", "tx request resumes", txReqN, 1'b0);
    drive(1, 1, 0, 1, 0, 0, 0);
    check("R9", "inactive when pin serves tx", txReqN, 1'b1);
    drive(1, 0, 1, 1, 0, 0, 0);
    check("R9", "inactive in wait mode", txReqN, 1'b1);
  endtask

  initial begin
    t_reset();
    t_disabled();
    t_req_tx();
    t_req_rx();
    t_req_consume();
    t_wait();
    t_txreq();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule